// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers of a 32-bit processor core that runs in seven operating modes. Every mode addresses sixteen 32-bit registers through a 4-bit index: 0 to 12 for general use, 13 for the stack pointer, 14 for the link register and 15 for the program counter. The current mode decides which physical copy an index reaches. The fast-interrupt mode owns private copies of indices 8 to 14, so its handler needs to save very little. The four other exception modes own private copies of the stack pointer and link register only. All remaining indices are shared.

The block has two combinational read ports and one write port, and all three use the same mode input. A user-bank override input steers all three ports to the user copies. Privileged code uses it to save or restore the state of an interrupted user task. When a read and the write reach the same physical register in one cycle, the read returns the incoming write data. The storage holds 31 physical words. The status register and the saved status registers live outside this block. The program counter's next value comes in through the write port.

Top module: `banked_regfile`

## Requirements
- R1: The mode input uses 5-bit codes: user=10000, fast-interrupt=10001, interrupt=10010, supervisor=10011, abort=10111, undefined=11011, system=11111.
- R2: Each port addresses sixteen 32-bit registers by a 4-bit index. The two read ports are combinational. A write with the enable high takes effect at the rising clock edge.
- R3: Indices 0 to 7 reach the same physical registers in every mode.
- R4: In fast-interrupt mode, indices 8 to 14 reach a private set that no other mode can reach. Writing them in that mode leaves the copies of the other modes unchanged.
- R5: Interrupt, supervisor, abort and undefined modes each have their own private copies of indices 13 and 14. Their indices 8 to 12 are shared with user mode.
- R6: Index 15 reaches one shared physical register in every mode.
- R7: System mode reaches the user copy for every index.
- R8: While the user-bank override is high, both reads and the write reach the user copies, whatever the mode input holds.
- R9: When the write enable is high and a read port targets the same physical register as the write, that port returns the write data in the same cycle.
- R10: A rising clock edge with the active-low reset held low clears every physical register to zero.
- R11: A mode code not listed in R1 maps the ports exactly as user mode does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 5 | Current processor mode code |
| user_bank_i | input | 1 | Force all ports to the user copies |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |

## Verification
The hardest state to reach is one where each physical copy holds a value that shows which mode last wrote it. Only then can a read-back show whether two modes share a register or each has its own copy. The stimulus therefore writes all sixteen indices in every mode in turn, with data that encodes the mode and the index. It then reads every index back under every mode. This way a wrongly shared copy or a wrongly split copy returns the tag of an unexpected writer. Directed cases then check the override from inside fast-interrupt mode, forwarding within one cycle, an unlisted mode code and a reset in the middle of a run.

// File: rtl/bank_pkg.sv
// Package: shared constants and types for the mode-banked register file.
// Assumes a fixed architectural layout of sixteen indices and 31 physical slots.
package bank_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_IDX  = 16;
    localparam int IDX_W    = $clog2(NUM_IDX);
    localparam int NUM_PHYS = 31;
    localparam int SLOT_W   = $clog2(NUM_PHYS);

    // First physical slot of each private group
    localparam int FIQ_BASE  = 16;   // indices 8..14 -> 16..22
    localparam int PAIR_BASE = 23;   // 4 pairs for indices 13,14 -> 23..30
    localparam int FIQ_LO    = 8;
    localparam int FIQ_HI    = 14;
    localparam int SP_IDX    = 13;

    // Mode codes seen on mode_i
    localparam logic [4:0] MD_USR = 5'b10000;
    localparam logic [4:0] MD_FIQ = 5'b10001;
    localparam logic [4:0] MD_IRQ = 5'b10010;
    localparam logic [4:0] MD_SVC = 5'b10011;
    localparam logic [4:0] MD_ABT = 5'b10111;
    localparam logic [4:0] MD_UND = 5'b11011;
    localparam logic [4:0] MD_SYS = 5'b11111;

    // Physical bank a mode selects
    typedef enum logic [2:0] {
        BK_USER = 3'd0,
        BK_FAST = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;

endpackage

// File: rtl/bank_map.sv
// Module: bank_map
// Converts a mode code, override flag and architectural index into a
// physical slot number. Purely combinational. Assumes the slot layout in
// bank_pkg; unknown mode codes fall back to the user bank.
module bank_map
    import bank_pkg::*;
(
    input  logic [4:0]        mode_i,
    input  logic              usr_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [SLOT_W-1:0] slot_o
);

    bank_e bank;

    // Decode the mode code into a physical bank, honouring the override
    always_comb begin
        if (usr_i) begin
            bank = BK_USER;
        end else begin
            unique case (mode_i)
                MD_FIQ:  bank = BK_FAST;
                MD_IRQ:  bank = BK_IRQ;
                MD_SVC:  bank = BK_SVC;
                MD_ABT:  bank = BK_ABT;
                MD_UND:  bank = BK_UND;
                default: bank = BK_USER;   // user, system and unlisted codes
            endcase
        end
    end

    logic             in_fast_rng;
    logic             in_pair_rng;
    logic [SLOT_W-1:0] idx_ext;
    logic [SLOT_W-1:0] pair_base;

    assign idx_ext     = SLOT_W'(idx_i);
    assign in_fast_rng = (int'(idx_i) >= FIQ_LO) && (int'(idx_i) <= FIQ_HI);
    assign in_pair_rng = (int'(idx_i) == SP_IDX) || (int'(idx_i) == SP_IDX + 1);
    assign pair_base   = SLOT_W'(PAIR_BASE) + SLOT_W'({bank - BK_IRQ, 1'b0});

    // Select the physical slot for the decoded bank
    always_comb begin
        slot_o = idx_ext;
        if (bank == BK_FAST && in_fast_rng) begin
            slot_o = SLOT_W'(FIQ_BASE) + idx_ext - SLOT_W'(FIQ_LO);
        end else if (bank != BK_USER && bank != BK_FAST && in_pair_rng) begin
            slot_o = pair_base + idx_ext - SLOT_W'(SP_IDX);
        end
    end

endmodule

// File: rtl/bank_store.sv
// Module: bank_store
// Physical storage of NUM_PHYS words with one write port and NUM_RD
// combinational read ports. Synchronous active-low reset clears all words.
// Assumes slot numbers below NUM_PHYS.
module bank_store #(
    parameter int DATA_W   = 32,
    parameter int NUM_PHYS = 31,
    parameter int NUM_RD   = 2,
    localparam int SLOT_W  = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] wslot_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SLOT_W-1:0] rslot_i [NUM_RD],
    output logic [DATA_W-1:0] rdata_o [NUM_RD]
);

    logic [DATA_W-1:0] mem [NUM_PHYS];

    // Clear on reset, otherwise store the write word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                mem[i] <= '0;
            end
        end else if (we_i) begin
            mem[wslot_i] <= wdata_i;
        end
    end

    // Plain array reads, one per port
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rdata_o[p] = mem[rslot_i[p]];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem[$past(wslot_i)] == $past(wdata_i)); // R2

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem[0] == '0 && mem[NUM_PHYS-1] == '0)); // R10

endmodule

// File: rtl/banked_regfile.sv
// Module: banked_regfile (top)
// Mode-banked register file: two combinational read ports with write-first
// forwarding and one write port, all mapped through bank_map. Assumes the
// caller holds mode_i and user_bank_i stable across each write edge.
module banked_regfile
    import bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic              user_bank_i,
    input  logic [3:0]        rd_a_idx,
    output logic [31:0]       rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [31:0]       rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [31:0]       wr_data
);

    localparam int NUM_RD = 2;

    logic [IDX_W-1:0]  rd_idx   [NUM_RD];
    logic [SLOT_W-1:0] rd_slot  [NUM_RD];
    logic [DATA_W-1:0] raw_data [NUM_RD];
    logic [DATA_W-1:0] rd_data  [NUM_RD];
    logic [SLOT_W-1:0] wr_slot;

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;
    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    // Write-side mapping
    bank_map u_map_wr (
        .mode_i (mode_i),
        .usr_i  (user_bank_i),
        .idx_i  (wr_idx),
        .slot_o (wr_slot)
    );

    // Read-side mapping and forwarding, one per port
    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        bank_map u_map_rd (
            .mode_i (mode_i),
            .usr_i  (user_bank_i),
            .idx_i  (rd_idx[p]),
            .slot_o (rd_slot[p])
        );
        assign rd_data[p] = (wr_en && wr_slot == rd_slot[p]) ? wr_data : raw_data[p];
    end

    bank_store #(
        .DATA_W   (DATA_W),
        .NUM_PHYS (NUM_PHYS),
        .NUM_RD   (NUM_RD)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .wslot_i (wr_slot),
        .wdata_i (wr_data),
        .rslot_i (rd_slot),
        .rdata_o (raw_data)
    );

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_slot) < NUM_PHYS); // R2

    AST_LOW_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx < 4'd8) |-> wr_slot == SLOT_W'(wr_idx)); // R3

    AST_PC_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 4'd15) |-> wr_slot == SLOT_W'(15)); // R6

    AST_FAST_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (mode_i != MD_FIQ || user_bank_i)) |->
            (int'(wr_slot) < FIQ_BASE || int'(wr_slot) >= PAIR_BASE)); // R4

    AST_OVERRIDE_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && user_bank_i) |-> wr_slot == SLOT_W'(wr_idx)); // R8

    AST_SYS_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_i == MD_SYS) |-> wr_slot == SLOT_W'(wr_idx)); // R7

endmodule

// File: tb/test_banked_regfile.sv
// Bench: writes a tagged value to every index under every mode, reads all
// back under every mode, then runs directed cases.
module test_banked_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'b10000;
    logic        user_bank_i = 1'b0;
    logic [3:0]  rd_a_idx = '0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    banked_regfile i_banked_regfile (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .user_bank_i(user_bank_i),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Mode table: user, fast, irq, svc, abt, und, sys (R1)
    localparam logic [4:0] MODES [7] = '{5'b10000, 5'b10001, 5'b10010,
                                         5'b10011, 5'b10111, 5'b11011, 5'b11111};

    function automatic logic [31:0] tag_val(int tag, int idx);
        return {4'(tag), 24'h0, 4'(idx)};
    endfunction

    // Tag of the last mode (1..7 in table order) to write the copy that
    // mode mi sees at idx, after all modes wrote in table order.
    function automatic int last_tag(int mi, int idx);
        if (mi == 1 && idx >= 8 && idx <= 14) return 2;          // R4
        if (mi >= 2 && mi <= 5 && idx >= 13 && idx <= 14) return mi + 1; // R5
        return 7;                                                // R3 R6 R7
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write(logic [4:0] m, logic ub, int idx, logic [31:0] d);
        @(negedge clk);
        mode_i = m; user_bank_i = ub; wr_en = 1'b1;
        wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read(logic [4:0] m, logic ub, int ia, int ib);
        mode_i = m; user_bank_i = ub;
        rd_a_idx = 4'(ia); rd_b_idx = 4'(ib);
        #2;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state, read through fast mode and user mode
        read(MODES[1], 1'b0, 9, 3);
        check("R10 reset fast r9", rd_a_data, 32'h0);
        check("R10 reset r3", rd_b_data, 32'h0);

        // Fill every index under every mode (R2)
        for (int m = 0; m < 7; m++) begin
            for (int i = 0; i < 16; i++) begin
                write(MODES[m], 1'b0, i, tag_val(m + 1, i));
            end
        end

        // Read back all indices under all modes on both ports
        @(negedge clk);
        for (int m = 0; m < 7; m++) begin
            for (int i = 0; i < 16; i++) begin
                read(MODES[m], 1'b0, i, 15 - i);
                check("R3-R7 table port A", rd_a_data, tag_val(last_tag(m, i), i));
                check("R2 table port B", rd_b_data,
                      tag_val(last_tag(m, 15 - i), 15 - i));
            end
        end

        // R4: fast-mode write of r10 leaves user r10 untouched
        write(MODES[1], 1'b0, 10, 32'hF00D_000A);
        read(MODES[0], 1'b0, 10, 10);
        check("R4 user r10 kept", rd_a_data, tag_val(7, 10));
        read(MODES[1], 1'b0, 10, 10);
        check("R4 fast r10 new", rd_a_data, 32'hF00D_000A);

        // R5: irq r13 private, irq r9 shared with user
        read(MODES[2], 1'b0, 13, 9);
        check("R5 irq r13", rd_a_data, tag_val(3, 13));
        check("R5 irq r9 shared", rd_b_data, tag_val(7, 9));

        // R8: override inside fast mode writes and reads user copies
        write(MODES[1], 1'b1, 12, 32'h0BAD_C0DE);
        read(MODES[1], 1'b1, 12, 14);
        check("R8 override read r12", rd_a_data, 32'h0BAD_C0DE);
        check("R8 override read r14", rd_b_data, tag_val(7, 14));
        read(MODES[0], 1'b0, 12, 12);
        check("R8 user r12", rd_a_data, 32'h0BAD_C0DE);
        read(MODES[1], 1'b0, 12, 12);
        check("R8 fast r12 kept", rd_a_data, tag_val(2, 12));

        // R11: unlisted code 00000 acts as user
        read(5'b00000, 1'b0, 13, 10);
        check("R11 unknown r13", rd_a_data, tag_val(7, 13));
        check("R11 unknown r10", rd_b_data, tag_val(7, 10));

        // R9: same-cycle forwarding on matching slot only
        @(negedge clk);
        mode_i = MODES[3]; user_bank_i = 1'b0;
        wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h1234_5678;
        rd_a_idx = 4'd14; rd_b_idx = 4'd13;
        #2;
        check("R9 forward port A", rd_a_data, 32'h1234_5678);
        check("R9 no forward port B", rd_b_data, tag_val(4, 13));
        @(negedge clk);
        wr_en = 1'b0;
        read(MODES[2], 1'b0, 14, 14);
        check("R9 irq r14 not hit", rd_a_data, tag_val(3, 14));

        // R10: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read(MODES[5], 1'b0, 13, 7);
        check("R10 mid reset und r13", rd_a_data, 32'h0);
        check("R10 mid reset r7", rd_b_data, 32'h0);
        read(MODES[1], 1'b0, 8, 15);
        check("R10 mid reset fast r8", rd_a_data, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule